// File: doc/BRIEF.md
# Virtually indexed, physically tagged L1 read lookup

This block is the read lookup path of a small set-associative L1 cache whose set index is drawn entirely from untranslated page-offset bits. A request carries only the low page-offset part of the virtual address. The block starts reading the tag, valid and data arrays in the request cycle, while an external TLB translates the virtual page number in parallel.

In the following cycle the TLB supplies the physical page number and a translation-miss flag. Every way's stored physical tag is compared against that number. The block then returns a hit flag and a 32-bit word taken from the matching line.

Lines are written through a refill port into the way picked by a per-set least-recently-used pointer. A single invalidate-all input empties the cache in one clock. Write handling, TLB internals and aliasing for caches larger than a page are outside this block.

Top module: `vipt_cache_lookup`

## Requirements
- R1: The set index is `req_off_i[11:4]` and the byte offset within the 16-byte line is `req_off_i[3:0]`. Index plus offset must fit inside the 12-bit page offset. `data_o` holds line bytes off, off+1, off+2, off+3 in bits [7:0], [15:8], [23:16], [31:24], where line byte b is `refill_line_i[8b+7:8b]`. Bytes past the end of the line read as zero.
- R2: `rsp_valid_o`, `hit_o` and `data_o` for a request are presented in the cycle after `req_valid_i` is sampled high. `rsp_valid_o` is low in a cycle that follows no request.
- R3: A response hits when some way of the indexed set is valid and its stored tag equals the `tlb_ppn_i` presented in the response cycle.
- R4: A valid line whose stored physical tag differs from `tlb_ppn_i` gives a miss, even though its set index matches.
- R5: When `tlb_miss_i` is high in the response cycle, `hit_o` is low even if a tag matches.
- R6: The two ways of a set hold two lines with different physical tags at the same time, and each one hits with its own data.
- R7: A refill writes the way named by the set's LRU pointer and points it at the other way. A hit points it at the way that did not hit. After refills A then B, a hit on A, and a refill C to the same set, C replaces B and A still hits.
- R8: `inval_all_i` clears every valid bit in one cycle, so later lookups miss. A refill in the same cycle is dropped.
- R9: After reset no line is valid and `rsp_valid_o` is low.
- R10: `data_o` is zero whenever `hit_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request |
| req_off_i | input | 12 | Untranslated page-offset bits of the virtual address |
| tlb_ppn_i | input | 20 | Translated physical page number, response cycle |
| tlb_miss_i | input | 1 | Translation failed, response cycle |
| rsp_valid_o | output | 1 | Response present |
| hit_o | output | 1 | Lookup hit |
| data_o | output | 32 | Word read from the hitting line |
| refill_valid_i | input | 1 | Write a line |
| refill_set_i | input | 8 | Set to refill |
| refill_ppn_i | input | 20 | Physical tag of the refilled line |
| refill_line_i | input | 128 | Line contents |
| inval_all_i | input | 1 | Clear all valid bits |

## Verification
Array reads are registered at the request edge, so each lookup's `rsp_valid_o`, `hit_o` and `data_o` become valid one clock later. They are combined with the page number that the bench presents on that later cycle. Every lookup task drives the request on a falling edge and presents the TLB result on the next falling edge. It samples the outputs shortly after that edge, in the response cycle. Refills and invalidates take effect at the rising edge after they are driven. LRU pointer moves from a hit land at the end of the response cycle, so they are observed only through later refills and lookups.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int unsigned DEF_PAGE_BITS   = 12;
  localparam int unsigned DEF_BLOCK_BYTES = 16;
  localparam int unsigned DEF_SETS        = 256;
  localparam int unsigned DEF_WAYS        = 2;
  localparam int unsigned DEF_PPN_BITS    = 20;
  localparam int unsigned DEF_WORD_BYTES  = 4;
endpackage

// File: rtl/vipt_tag_way.sv
module vipt_tag_way #(
  parameter int unsigned SETS  = 256,
  parameter int unsigned TAG_W = 20,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             inval_i,
  output logic             rd_valid_o,
  output logic [TAG_W-1:0] rd_tag_o
);
  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      if (inval_i)      valid_q <= '0;
      else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
      if (rd_en_i)      rd_valid_o <= valid_q[rd_idx_i];
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_idx_i] <= wr_tag_i;
    if (rd_en_i) rd_tag_o <= tag_q[rd_idx_i];
  end

  AST_INVAL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> (valid_q == '0)); // R8
  AST_REFILL_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !inval_i) |=> valid_q[$past(wr_idx_i)]); // R6
endmodule

// File: rtl/vipt_data_way.sv
module vipt_data_way #(
  parameter int unsigned SETS   = 256,
  parameter int unsigned LINE_W = 128,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [LINE_W-1:0] wr_line_i,
  output logic [LINE_W-1:0] rd_line_o
);
  logic [LINE_W-1:0] mem_q [SETS];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_line_i;
    if (rd_en_i) rd_line_o <= mem_q[rd_idx_i];
  end
endmodule

// File: rtl/vipt_lru.sv
module vipt_lru #(
  parameter int unsigned SETS  = 256,
  parameter int unsigned WAYS  = 2,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             refill_i,
  input  logic [IDX_W-1:0] refill_idx_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] hit_idx_i,
  input  logic [WAY_W-1:0] hit_way_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [WAY_W-1:0] lru_q [SETS];

  assign victim_o = lru_q[refill_idx_i];

  // refill is written last so it wins a same-set collision with a hit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
    end else begin
      if (hit_i)    lru_q[hit_idx_i]    <= hit_way_i + 1'b1;
      if (refill_i) lru_q[refill_idx_i] <= victim_o + 1'b1;
    end
  end

  AST_LRU_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_i |=> (lru_q[$past(refill_idx_i)] != $past(victim_o))); // R7
endmodule

// File: rtl/vipt_cache_lookup.sv
module vipt_cache_lookup
  import vipt_pkg::*;
#(
  parameter int unsigned PAGE_BITS   = DEF_PAGE_BITS,
  parameter int unsigned BLOCK_BYTES = DEF_BLOCK_BYTES,
  parameter int unsigned SETS        = DEF_SETS,
  parameter int unsigned WAYS        = DEF_WAYS,
  parameter int unsigned PPN_BITS    = DEF_PPN_BITS,
  parameter int unsigned WORD_BYTES  = DEF_WORD_BYTES,
  localparam int unsigned OFF_BITS   = $clog2(BLOCK_BYTES),
  localparam int unsigned IDX_BITS   = $clog2(SETS),
  localparam int unsigned REQ_BITS   = OFF_BITS + IDX_BITS,
  localparam int unsigned WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned LINE_W     = 8 * BLOCK_BYTES,
  localparam int unsigned WORD_W     = 8 * WORD_BYTES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [REQ_BITS-1:0] req_off_i,
  input  logic [PPN_BITS-1:0] tlb_ppn_i,
  input  logic                tlb_miss_i,
  output logic                rsp_valid_o,
  output logic                hit_o,
  output logic [WORD_W-1:0]   data_o,
  input  logic                refill_valid_i,
  input  logic [IDX_BITS-1:0] refill_set_i,
  input  logic [PPN_BITS-1:0] refill_ppn_i,
  input  logic [LINE_W-1:0]   refill_line_i,
  input  logic                inval_all_i
);
  logic [IDX_BITS-1:0] req_idx;
  logic [IDX_BITS-1:0] idx_q;
  logic [OFF_BITS-1:0] boff_q;
  logic                rsp_q;
  logic                refill_we;
  logic [WAY_W-1:0]    victim;
  logic [WAYS-1:0]     rd_valid;
  logic [WAYS-1:0]     way_hit;
  logic [PPN_BITS-1:0] rd_tag  [WAYS];
  logic [LINE_W-1:0]   rd_line [WAYS];
  logic [WAY_W-1:0]    hit_way;
  logic                any_hit;
  logic [LINE_W-1:0]   shifted;

  // index comes from untranslated bits only; arrays read alongside the TLB
  assign req_idx   = req_off_i[OFF_BITS +: IDX_BITS];
  assign refill_we = refill_valid_i && !inval_all_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q  <= 1'b0;
      idx_q  <= '0;
      boff_q <= '0;
    end else begin
      rsp_q <= req_valid_i;
      if (req_valid_i) begin
        idx_q  <= req_idx;
        boff_q <= req_off_i[OFF_BITS-1:0];
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic way_we;
    assign way_we = refill_we && (victim == WAY_W'(w));

    vipt_tag_way #(.SETS(SETS), .TAG_W(PPN_BITS)) u_tag (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_en_i   (req_valid_i),
      .rd_idx_i  (req_idx),
      .wr_en_i   (way_we),
      .wr_idx_i  (refill_set_i),
      .wr_tag_i  (refill_ppn_i),
      .inval_i   (inval_all_i),
      .rd_valid_o(rd_valid[w]),
      .rd_tag_o  (rd_tag[w])
    );

    vipt_data_way #(.SETS(SETS), .LINE_W(LINE_W)) u_data (
      .clk_i    (clk_i),
      .rd_en_i  (req_valid_i),
      .rd_idx_i (req_idx),
      .wr_en_i  (way_we),
      .wr_idx_i (refill_set_i),
      .wr_line_i(refill_line_i),
      .rd_line_o(rd_line[w])
    );

    // late compare against the translated page number
    assign way_hit[w] = rd_valid[w] && (rd_tag[w] == tlb_ppn_i);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) hit_way = WAY_W'(w);
    end
  end

  assign any_hit     = |way_hit;
  assign rsp_valid_o = rsp_q;
  assign hit_o       = rsp_q && !tlb_miss_i && any_hit;
  assign shifted     = rd_line[hit_way] >> {boff_q, 3'b000};
  assign data_o      = hit_o ? shifted[WORD_W-1:0] : '0;

  vipt_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .refill_i    (refill_we),
    .refill_idx_i(refill_set_i),
    .hit_i       (hit_o),
    .hit_idx_i   (idx_q),
    .hit_way_i   (hit_way),
    .victim_o    (victim)
  );

  initial AST_INDEX_IN_PAGE: assert (REQ_BITS <= PAGE_BITS); // R1

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R2
  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R2
  AST_TLB_MISS_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_miss_i |-> !hit_o); // R5
  AST_DATA_ZERO_ON_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (data_o == '0)); // R10
  AST_HIT_NEEDS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> rsp_valid_o); // R3
endmodule

// File: tb/vipt_cache_lookup_bench.sv
module vipt_cache_lookup_bench;
  localparam time CLK_P = 20ns;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic [11:0]  req_off_i = '0;
  logic [19:0]  tlb_ppn_i = '0;
  logic         tlb_miss_i = 1'b0;
  logic         rsp_valid_o;
  logic         hit_o;
  logic [31:0]  data_o;
  logic         refill_valid_i = 1'b0;
  logic [7:0]   refill_set_i = '0;
  logic [19:0]  refill_ppn_i = '0;
  logic [127:0] refill_line_i = '0;
  logic         inval_all_i = 1'b0;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  vipt_cache_lookup u_vipt_cache_lookup (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_off_i(req_off_i),
    .tlb_ppn_i(tlb_ppn_i), .tlb_miss_i(tlb_miss_i), .rsp_valid_o(rsp_valid_o),
    .hit_o(hit_o), .data_o(data_o), .refill_valid_i(refill_valid_i),
    .refill_set_i(refill_set_i), .refill_ppn_i(refill_ppn_i),
    .refill_line_i(refill_line_i), .inval_all_i(inval_all_i)
  );

  function automatic logic [127:0] mk_line(input logic [7:0] seed);
    logic [127:0] l;
    for (int b = 0; b < 16; b++) l[8*b +: 8] = seed + 8'(b);
    return l;
  endfunction

  function automatic logic [31:0] exp_word(input logic [127:0] l, input int off);
    logic [31:0] w;
    w = '0;
    for (int k = 0; k < 4; k++) if (off + k < 16) w[8*k +: 8] = l[8*(off+k) +: 8];
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic refill(input logic [7:0] set, input logic [19:0] ppn,
                        input logic [127:0] line, input logic inval);
    @(negedge clk_i);
    refill_valid_i = 1'b1; refill_set_i = set; refill_ppn_i = ppn;
    refill_line_i = line; inval_all_i = inval;
    @(negedge clk_i);
    refill_valid_i = 1'b0; inval_all_i = 1'b0;
  endtask

  task automatic lookup(input logic [7:0] set, input logic [3:0] off, input logic [19:0] ppn,
                        input logic miss, output logic rv, output logic h, output logic [31:0] d);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_off_i = {set, off};
    @(negedge clk_i);
    req_valid_i = 1'b0; tlb_ppn_i = ppn; tlb_miss_i = miss;
    #2;
    rv = rsp_valid_o; h = hit_o; d = data_o;
    tlb_miss_i = 1'b0;
  endtask

  task automatic t_reset();
    logic rv, h; logic [31:0] d;
    check("R9 rsp_valid idle after reset", 32'(rsp_valid_o), 32'd0);
    lookup(8'h05, 4'h0, 20'h0, 1'b0, rv, h, d);
    check("R2 rsp_valid one cycle after request", 32'(rv), 32'd1);
    check("R9 no valid line after reset", 32'(h), 32'd0);
    check("R10 data zero on miss", d, 32'd0);
    @(negedge clk_i); #2;
    check("R2 rsp_valid low without request", 32'(rsp_valid_o), 32'd0);
  endtask

  task automatic t_basic();
    logic rv, h; logic [31:0] d;
    logic [127:0] l = mk_line(8'hA0);
    refill(8'h10, 20'h12345, l, 1'b0);
    lookup(8'h10, 4'h0, 20'h12345, 1'b0, rv, h, d);
    check("R3 hit on matching tag", 32'(h), 32'd1);
    check("R1 word at offset 0", d, exp_word(l, 0));
    lookup(8'h10, 4'h5, 20'h12345, 1'b0, rv, h, d);
    check("R1 word at offset 5", d, exp_word(l, 5));
    lookup(8'h10, 4'hE, 20'h12345, 1'b0, rv, h, d);
    check("R1 word past line end", d, exp_word(l, 14));
    lookup(8'h11, 4'h0, 20'h12345, 1'b0, rv, h, d);
    check("R1 other set misses", 32'(h), 32'd0);
  endtask

  task automatic t_tag_mismatch();
    logic rv, h; logic [31:0] d;
    lookup(8'h10, 4'h0, 20'h12346, 1'b0, rv, h, d);
    check("R4 physical tag mismatch misses", 32'(h), 32'd0);
    check("R10 data zero on tag mismatch", d, 32'd0);
  endtask

  task automatic t_tlb_miss();
    logic rv, h; logic [31:0] d;
    lookup(8'h10, 4'h0, 20'h12345, 1'b1, rv, h, d);
    check("R5 translation miss suppresses hit", 32'(h), 32'd0);
    check("R10 data zero on translation miss", d, 32'd0);
  endtask

  task automatic t_two_ways();
    logic rv, h; logic [31:0] d;
    refill(8'h20, 20'h0AAAA, mk_line(8'h10), 1'b0);
    refill(8'h20, 20'h0BBBB, mk_line(8'h50), 1'b0);
    lookup(8'h20, 4'h4, 20'h0AAAA, 1'b0, rv, h, d);
    check("R6 first way hit", 32'(h), 32'd1);
    check("R6 first way data", d, exp_word(mk_line(8'h10), 4));
    lookup(8'h20, 4'h4, 20'h0BBBB, 1'b0, rv, h, d);
    check("R6 second way hit", 32'(h), 32'd1);
    check("R6 second way data", d, exp_word(mk_line(8'h50), 4));
  endtask

  task automatic t_lru();
    logic rv, h; logic [31:0] d;
    refill(8'h30, 20'h00A01, mk_line(8'h20), 1'b0);
    refill(8'h30, 20'h00B02, mk_line(8'h40), 1'b0);
    lookup(8'h30, 4'h0, 20'h00A01, 1'b0, rv, h, d);
    check("R7 A hits before replacement", 32'(h), 32'd1);
    refill(8'h30, 20'h00C03, mk_line(8'h60), 1'b0);
    lookup(8'h30, 4'h0, 20'h00A01, 1'b0, rv, h, d);
    check("R7 recently used A kept", 32'(h), 32'd1);
    lookup(8'h30, 4'h0, 20'h00B02, 1'b0, rv, h, d);
    check("R7 least recently used B evicted", 32'(h), 32'd0);
    lookup(8'h30, 4'h8, 20'h00C03, 1'b0, rv, h, d);
    check("R7 C hits", 32'(h), 32'd1);
    check("R7 C data", d, exp_word(mk_line(8'h60), 8));
  endtask

  task automatic t_inval();
    logic rv, h; logic [31:0] d;
    refill(8'h40, 20'h0DDDD, mk_line(8'h70), 1'b1);
    lookup(8'h10, 4'h0, 20'h12345, 1'b0, rv, h, d);
    check("R8 invalidated line misses", 32'(h), 32'd0);
    lookup(8'h20, 4'h0, 20'h0BBBB, 1'b0, rv, h, d);
    check("R8 other invalidated line misses", 32'(h), 32'd0);
    lookup(8'h40, 4'h0, 20'h0DDDD, 1'b0, rv, h, d);
    check("R8 refill during invalidate dropped", 32'(h), 32'd0);
    refill(8'h40, 20'h0DDDD, mk_line(8'h70), 1'b0);
    lookup(8'h40, 4'h1, 20'h0DDDD, 1'b0, rv, h, d);
    check("R8 refill after invalidate hits", 32'(h), 32'd1);
    check("R8 refill after invalidate data", d, exp_word(mk_line(8'h70), 1));
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #2;
    t_reset();
    t_basic();
    t_tag_mismatch();
    t_tlb_miss();
    t_two_ways();
    t_lru();
    t_inval();
    repeat (2) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule